// File: doc/BRIEF.md
# ASID-aware TLB tag array

This block is the tag side of a small fully associative address-translation cache. Each of its lines records whether it is in use, a virtual page key, the address-space identifier it was filled under, and a flag marking the mapping as global. A lookup compares one virtual page number against every line in the same cycle. The current address-space identifier is taken from the translation control register. The result is a hit flag and a vector with one bit per line.

A fill port loads a new entry into the line chosen by a round-robin replacement pointer. A flush port models the effect of an address-translation fence. When the fence's ASID operand is register x0, the fence is a full flush and the flush-all qualifier is driven high; this removes every line. When the operand is any other register, the fence is ASID-scoped and the qualifier is low; this removes only the lines that are not global. Global lines match under every address-space identifier. Switching the identifier in the control register is not a fence, so it leaves every line in place.

Top module: `tlbtag_array`

## Requirements
- R1: After reset every line is empty: no lookup hits, and the replacement pointer `fill_slot_o` is 0.
- R2: The current ASID is bits 59:44 of `xlat_ctrl_i`. The mode field in bits 63:60 (9 selects the four-level scheme) and the root page number in bits 43:0 have no effect on a lookup.
- R3: A line hits when it is valid, its stored key equals `lk_vpn_i`, and its ASID matches. `lk_hit_o` is the OR of `lk_hit_vec_o`. The lookup is combinational in the same cycle.
- R4: The ASID match is true for a global line under any current ASID.
- R5: A non-global line whose stored ASID differs from the current ASID does not hit, even when its key matches.
- R6: A fill that is accepted writes key, ASID, global flag and valid into line `fill_slot_o`. The entry can be looked up from the next cycle. The pointer then advances by one and wraps from LINES-1 to 0.
- R7: A flush with `flush_all_i`=0 (ASID operand not x0) invalidates every non-global line and keeps every global line resident.
- R8: A flush with `flush_all_i`=1 (ASID operand x0) invalidates every line, global ones included.
- R9: When a flush and a fill arrive in the same cycle, the flush takes effect. The fill is dropped, and the pointer does not move.
- R10: Changing the ASID in `xlat_ctrl_i` invalidates nothing. A line that hit before the change hits again once its ASID is restored.
- R11: Bit i of `lk_hit_vec_o` belongs to line i, which is the line written when `fill_slot_o` was i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| xlat_ctrl_i | input | 64 | Translation control word; bits 59:44 give the current ASID |
| lk_vpn_i | input | VPN_W | Virtual page number to look up |
| lk_hit_vec_o | output | LINES | One bit per line that matches |
| lk_hit_o | output | 1 | Some line matches |
| fill_en_i | input | 1 | Fill strobe |
| fill_vpn_i | input | VPN_W | Key to store |
| fill_asid_i | input | 16 | ASID to store |
| fill_global_i | input | 1 | Global flag to store |
| fill_slot_o | output | $clog2(LINES) | Replacement pointer: the line the next fill will write |
| flush_en_i | input | 1 | Flush strobe |
| flush_all_i | input | 1 | 1 = full flush (ASID operand is x0), 0 = ASID-scoped flush |

## Verification
The case that is hardest to reach from the ports is a global line that has survived a scoped flush and is then hit under an ASID it was never filled with. To get there, the stimulus must place a global line and a non-global line side by side and issue the scoped flush. It then looks up the global key under an ASID that differs from the stored one, which shows both that the line survived and that the match ignores the ASID. A second hard case is a flush and a fill in the same cycle. Here the stimulus first walks the pointer to a known slot, then drives both strobes together and observes the pointer and a lookup of the key that was dropped.

// File: rtl/tlbtag_pkg.sv
package tlbtag_pkg;
  localparam int unsigned ASID_W = 16;
  localparam int unsigned CTRL_W = 64;
  localparam int unsigned ASID_LO = 44;

  function automatic logic [ASID_W-1:0] asid_from_ctrl(input logic [CTRL_W-1:0] ctrl);
    return ctrl[ASID_LO +: ASID_W];
  endfunction

  function automatic logic asid_ok(input logic [ASID_W-1:0] stored,
                                   input logic [ASID_W-1:0] cur,
                                   input logic glob);
    return glob | (stored == cur);
  endfunction

  function automatic logic line_kill(input logic flush, input logic all, input logic glob);
    return flush & (all | ~glob);
  endfunction
endpackage

// File: rtl/tlbtag_line.sv
module tlbtag_line
  import tlbtag_pkg::*;
#(
  parameter int unsigned VPN_W = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic              flush_i,
  input  logic              flush_all_i,
  input  logic [VPN_W-1:0]  look_vpn_i,
  input  logic [ASID_W-1:0] look_asid_i,
  output logic              match_o
);
  logic              valid_q;
  logic              global_q;
  logic [ASID_W-1:0] asid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic              kill_w;
  logic              key_eq_w;
  logic              asid_eq_w;

  assign kill_w    = line_kill(flush_i, flush_all_i, global_q);
  assign key_eq_w  = (vpn_q == look_vpn_i);
  assign asid_eq_w = asid_ok(asid_q, look_asid_i, global_q);
  assign match_o   = valid_q & key_eq_w & asid_eq_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      global_q <= 1'b0;
      asid_q   <= '0;
      vpn_q    <= '0;
    end else if (kill_w) begin
      valid_q <= 1'b0;
    end else if (wr_i && !flush_i) begin
      valid_q  <= 1'b1;
      global_q <= wr_global_i;
      asid_q   <= wr_asid_i;
      vpn_q    <= wr_vpn_i;
    end
  end

  // R8
  flush_all_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && flush_all_i |=> !valid_q);
  // R7
  scoped_drops_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !flush_all_i && !global_q |=> !valid_q);
  // R7
  scoped_keeps_global_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !flush_all_i && global_q && valid_q |=> valid_q);
  // R5
  local_needs_asid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o && !global_q |-> asid_q == look_asid_i);
endmodule

// File: rtl/tlbtag_repl.sv
module tlbtag_repl #(
  parameter int unsigned LINES = 8,
  localparam int unsigned PTR_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_ok_i,
  output logic [PTR_W-1:0] slot_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LINES - 1);
  logic [PTR_W-1:0] slot_q;
  logic             wrap_w;

  assign wrap_w = (slot_q == LAST);
  assign slot_o = slot_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        slot_q <= '0;
    else if (fill_ok_i) slot_q <= wrap_w ? '0 : slot_q + 1'b1;
  end

  // R6
  slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ok_i && !wrap_w |=> slot_q == $past(slot_q) + 1'b1);
  // R6
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ok_i && wrap_w |=> slot_q == '0);
  // R9
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_ok_i |=> $stable(slot_q));
endmodule

// File: rtl/tlbtag_array.sv
module tlbtag_array
  import tlbtag_pkg::*;
#(
  parameter int unsigned LINES = 8,
  parameter int unsigned VPN_W = 27,
  localparam int unsigned PTR_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       xlat_ctrl_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic [LINES-1:0]  lk_hit_vec_o,
  output logic              lk_hit_o,
  input  logic              fill_en_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_global_i,
  output logic [PTR_W-1:0]  fill_slot_o,
  input  logic              flush_en_i,
  input  logic              flush_all_i
);
  logic [ASID_W-1:0] cur_asid_w;
  logic              fill_ok_w;
  logic              fill_drop_w;
  logic [PTR_W-1:0]  slot_w;

  assign cur_asid_w  = asid_from_ctrl(xlat_ctrl_i);
  assign fill_ok_w   = fill_en_i & ~flush_en_i;
  assign fill_drop_w = fill_en_i & flush_en_i;

  tlbtag_repl #(.LINES(LINES)) repl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fill_ok_i (fill_ok_w),
    .slot_o    (slot_w)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel_w;
    assign sel_w = fill_ok_w & (slot_w == PTR_W'(i));
    tlbtag_line #(.VPN_W(VPN_W)) line_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (sel_w),
      .wr_vpn_i    (fill_vpn_i),
      .wr_asid_i   (fill_asid_i),
      .wr_global_i (fill_global_i),
      .flush_i     (flush_en_i),
      .flush_all_i (flush_all_i),
      .look_vpn_i  (lk_vpn_i),
      .look_asid_i (cur_asid_w),
      .match_o     (lk_hit_vec_o[i])
    );
  end

  assign lk_hit_o    = |lk_hit_vec_o;
  assign fill_slot_o = slot_w;

  // R9
  flush_fill_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_drop_w |=> $stable(fill_slot_o));
  // R8
  full_flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_en_i && flush_all_i |=> !lk_hit_o);
endmodule

// File: tb/tlbtag_array_tb_top.sv
module tlbtag_array_tb_top;
  localparam int LINES = 8;
  localparam int VPN_W = 27;
  localparam int PTR_W = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] ctrl = '0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [LINES-1:0] hit_vec;
  logic hit;
  logic fill_en = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [15:0] fill_asid = '0;
  logic fill_g = 1'b0;
  logic [PTR_W-1:0] slot;
  logic flush_en = 1'b0;
  logic flush_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlbtag_array #(.LINES(LINES), .VPN_W(VPN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xlat_ctrl_i(ctrl), .lk_vpn_i(lk_vpn),
    .lk_hit_vec_o(hit_vec), .lk_hit_o(hit), .fill_en_i(fill_en),
    .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid), .fill_global_i(fill_g),
    .fill_slot_o(slot), .flush_en_i(flush_en), .flush_all_i(flush_all)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 lookup, 1 fill, 2 flush
    logic [15:0] asid;
    logic [7:0]  vpn;
    logic        g;
    logic        all;
    logic        xhit;
    logic [7:0]  xvec;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TABLE [NV] = '{
    '{2'd0, 16'h0001, 8'h05, 1'b0, 1'b0, 1'b0, 8'h00}, // R1 empty
    '{2'd1, 16'h0001, 8'h10, 1'b0, 1'b0, 1'b0, 8'h00}, // line0
    '{2'd1, 16'h0001, 8'h11, 1'b1, 1'b0, 1'b0, 8'h00}, // line1 global
    '{2'd1, 16'h0002, 8'h12, 1'b0, 1'b0, 1'b0, 8'h00}, // line2
    '{2'd0, 16'h0001, 8'h10, 1'b0, 1'b0, 1'b1, 8'h01}, // R3 R11
    '{2'd0, 16'h0002, 8'h10, 1'b0, 1'b0, 1'b0, 8'h00}, // R5
    '{2'd0, 16'h0002, 8'h11, 1'b0, 1'b0, 1'b1, 8'h02}, // R4
    '{2'd0, 16'h0007, 8'h11, 1'b0, 1'b0, 1'b1, 8'h02}, // R4
    '{2'd0, 16'h0002, 8'h12, 1'b0, 1'b0, 1'b1, 8'h04}, // R11
    '{2'd0, 16'h0002, 8'h13, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 key
    '{2'd0, 16'h0001, 8'h10, 1'b0, 1'b0, 1'b1, 8'h01}, // R10
    '{2'd2, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // scoped flush
    '{2'd0, 16'h0001, 8'h10, 1'b0, 1'b0, 1'b0, 8'h00}, // R7
    '{2'd0, 16'h0002, 8'h12, 1'b0, 1'b0, 1'b0, 8'h00}, // R7
    '{2'd0, 16'h0003, 8'h11, 1'b0, 1'b0, 1'b1, 8'h02}, // R7 global kept
    '{2'd2, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // full flush
    '{2'd0, 16'h0003, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00}  // R8
  };

  function automatic logic [63:0] mk_ctrl(input logic [15:0] a, input logic [43:0] root);
    return {4'h9, a, root};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [7:0] v, input logic [15:0] a, input logic g);
    @(negedge clk);
    fill_vpn = VPN_W'(v); fill_asid = a; fill_g = g; fill_en = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush(input logic all, input logic with_fill);
    @(negedge clk);
    flush_en = 1'b1; flush_all = all; fill_en = with_fill;
    @(negedge clk);
    flush_en = 1'b0; flush_all = 1'b0; fill_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [63:0] c, input logic [7:0] v,
                      input logic xh, input logic [7:0] xv);
    @(negedge clk);
    ctrl = c; lk_vpn = VPN_W'(v);
    #1;
    check(req, 64'(hit), 64'(xh));
    check(req, 64'(hit_vec), 64'(xv));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 slot", 64'(slot), 64'd0);
    check("R1 hit", 64'(hit), 64'd0);

    for (int k = 0; k < NV; k++) begin
      case (TABLE[k].op)
        2'd1: do_fill(TABLE[k].vpn, TABLE[k].asid, TABLE[k].g);
        2'd2: do_flush(TABLE[k].all, 1'b0);
        default: look($sformatf("R3/R4/R5/R7/R8/R10/R11 row %0d", k),
                      mk_ctrl(TABLE[k].asid, 44'h000_0008_0080),
                      TABLE[k].vpn, TABLE[k].xhit, TABLE[k].xvec);
      endcase
    end

    // R6: pointer sits at 3 after three fills
    check("R6 slot after 3", 64'(slot), 64'd3);

    // R2: only bits 59:44 matter
    do_fill(8'h20, 16'h00AB, 1'b0);
    look("R2 other bits set", {4'h9, 16'h00AB, 44'hFFF_FFFF_FFFF}, 8'h20, 1'b1, 8'h08);
    look("R2 other bits zero", {4'h0, 16'h00AB, 44'h0}, 8'h20, 1'b1, 8'h08);
    look("R2 asid differs", {4'h9, 16'h00AA, 44'hFFF_FFFF_FFFF}, 8'h20, 1'b0, 8'h00);

    // R6: fill lines 4..7 and wrap
    for (int i = 4; i < 8; i++) begin
      check("R6 slot step", 64'(slot), 64'(i));
      do_fill(8'(8'h50 + i), 16'h0005, 1'b0);
    end
    check("R6 wrap", 64'(slot), 64'd0);
    look("R6 line7", mk_ctrl(16'h0005, 44'h1), 8'h57, 1'b1, 8'h80);
    do_fill(8'h30, 16'h0005, 1'b0);
    look("R6 R11 line0 refill", mk_ctrl(16'h0005, 44'h1), 8'h30, 1'b1, 8'h01);
    check("R6 slot one", 64'(slot), 64'd1);

    // R9: fill with flush in same cycle
    @(negedge clk);
    fill_vpn = VPN_W'(8'h40); fill_asid = 16'h0005; fill_g = 1'b1;
    do_flush(1'b0, 1'b1);
    #1;
    check("R9 slot hold", 64'(slot), 64'd1);
    look("R9 fill dropped", mk_ctrl(16'h0005, 44'h1), 8'h40, 1'b0, 8'h00);
    look("R7 line0 flushed", mk_ctrl(16'h0005, 44'h1), 8'h30, 1'b0, 8'h00);

    // R10: global survives asid changes without a fence
    do_fill(8'h61, 16'h0009, 1'b1);
    look("R10 global other asid", mk_ctrl(16'h0123, 44'h1), 8'h61, 1'b1, 8'h02);
    look("R10 global own asid", mk_ctrl(16'h0009, 44'h1), 8'h61, 1'b1, 8'h02);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule